// File: doc/BRIEF.md
# Named Hardware Barrier Unit

This unit lets a group of concurrently running waves meet at a common point. It holds a small pool of numbered barriers. Every wave addresses a barrier through an encoded handle and issues one operation at a time on a request port: an explicit init, a signal that may carry a member count, a join, a wait, or a leave. For each barrier the unit keeps a member count and the number of arrivals in the current phase. For each wave it keeps the barrier that the wave joined last, together with that wave's progress in the phase.

A barrier completes once its arrivals reach its member count. The arrival counter then returns to zero and the member count is kept, so the same barrier can run the next phase. Waves that are stalled on the completed barrier are released one per cycle on a release pulse, lowest wave ID first. New requests are held off until the last pulse has gone out. A wave that leaves lowers the member count, which can complete the barrier on the spot. A malformed request raises a one-cycle error pulse and changes nothing.

Top module: `namedbar_unit`

## Requirements
- R1: A handle is 0x0080_0000 OR (id << 4). Ids 1 to 16 name barriers and 0x0080_0000 is the null barrier. Any other value is malformed, including ids 17 to 31, a set bit in [3:0], or bits outside [8:4] that differ from the base. Init or signal with a null or malformed handle, or join with a malformed handle, sets errPulse high in the cycle after acceptance and has no other effect.
- R2: A signal (reqOp=1) with a nonzero reqCount sets the barrier's member count to reqCount and records one arrival. A signal with reqCount=0 records one arrival only.
- R3: An init (reqOp=0) sets the member count to reqCount and clears the arrivals. It records no arrival.
- R4: A barrier completes when its arrivals reach a nonzero member count. Every wave stalled on it is then released. Starting in the cycle after the completing request is accepted, relValid is high for one cycle per released wave, and relWave carries the released wave IDs in ascending order.
- R5: On completion the arrival counter returns to zero and the member count is kept. The next phase completes after the same number of zero-count signals.
- R6: A join (reqOp=2) makes the barrier the wave's current one and leaves the member count unchanged. A wait (reqOp=3) applies to the wave's current barrier. A wait issued after that barrier has already completed the wave's signaled phase releases the wave in the next cycle.
- R7: A leave (reqOp=4) applies to the wave's current barrier and lowers its member count by one. If the arrivals then reach the new nonzero count, the barrier completes at once. The leaving wave's current barrier becomes null.
- R8: Wait and leave require reqType=1. Any other value raises errPulse and has no effect.
- R9: A wait or leave from a wave whose current barrier is null raises errPulse and does not stall the wave.
- R10: One request is accepted per cycle, when reqValid and reqReady are both high. reqReady is low while release pulses are pending.
- R11: waveStalled[w] goes high in the cycle after wave w's wait is accepted. It stays high through w's release pulse and is low in the cycle after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit can accept a request |
| reqOp | input | 3 | 0 init, 1 signal, 2 join, 3 wait, 4 leave |
| reqWave | input | $clog2(NUM_WAVES) | Issuing wave ID |
| reqHandle | input | 32 | Encoded barrier handle for init, signal and join |
| reqCount | input | $clog2(NUM_WAVES+1) | Member count for init and signal |
| reqType | input | 2 | Barrier-type operand for wait and leave, must be 1 |
| relValid | output | 1 | Release pulse |
| relWave | output | $clog2(NUM_WAVES) | Wave released this cycle |
| waveStalled | output | NUM_WAVES | Per-wave wait outstanding |
| errPulse | output | 1 | Rejected request, one cycle |

## Verification
The main sweep runs every barrier ID with every member count from one to four waves. In each run the last member signals while its peers are already stalled, then waits afterwards. This separates the release of waves that were already stalled from a wait that arrives after completion. Each run is followed by a second phase of zero-count signals, which tells a retained member count apart from a lost one. A second sweep walks every value of the id field of a handle and several malformed variants, which separates legal, null, out-of-range and corrupt handles. Directed cases cover a count set by init without an arrival, a leave that completes the barrier, a leave that does not, and rejected type operands. A later completion shows that a rejected request left the state untouched.

// File: rtl/namedbar_pkg.sv
package namedbar_pkg;

  typedef enum logic [2:0] {
    OP_INIT   = 3'd0,
    OP_SIGNAL = 3'd1,
    OP_JOIN   = 3'd2,
    OP_WAIT   = 3'd3,
    OP_LEAVE  = 3'd4
  } barOp_e;

  localparam logic [31:0] HANDLE_BASE  = 32'h0080_0000;
  localparam int          HANDLE_SHIFT = 4;
  localparam logic [1:0]  SYNC_TYPE    = 2'd1;

  // strobes from control to datapath, at most one operation bit set
  typedef struct packed {
    logic doInit;
    logic doSignal;
    logic doJoin;
    logic doWait;
    logic doLeave;
    logic doErr;
  } barStrobe_t;

endpackage

// File: rtl/namedbar_hdec.sv
module namedbar_hdec
  import namedbar_pkg::*;
#(
  parameter int NUM_BARRIERS = 16,
  localparam int IDW = $clog2(NUM_BARRIERS + 1)
) (
  input  logic [31:0]    handle,
  output logic [IDW-1:0] barId,
  output logic           isNull,
  output logic           isLegal
);

  localparam logic [31:0]    FIELD_MASK = ((32'd1 << IDW) - 32'd1) << HANDLE_SHIFT;
  localparam logic [IDW-1:0] MAX_ID     = IDW'(NUM_BARRIERS);

  logic wellFormed;

  always_comb begin
    barId      = handle[HANDLE_SHIFT +: IDW];
    wellFormed = (handle & ~FIELD_MASK) == HANDLE_BASE;
    isNull     = wellFormed && (barId == '0);
    isLegal    = wellFormed && (barId != '0) && (barId <= MAX_ID);
  end

endmodule

// File: rtl/namedbar_ctrl.sv
module namedbar_ctrl
  import namedbar_pkg::*;
#(
  parameter int NUM_BARRIERS = 16,
  localparam int IDW = $clog2(NUM_BARRIERS + 1)
) (
  input  logic             accept,
  input  logic [2:0]       reqOp,
  input  logic [1:0]       reqType,
  input  logic [IDW-1:0]   handleId,
  input  logic             handleNull,
  input  logic             handleLegal,
  input  logic [IDW-1:0]   curJoined,
  output barStrobe_t       stb,
  output logic [IDW-1:0]   tgtId
);

  logic joinedOk;

  always_comb begin
    stb      = '0;
    tgtId    = handleId;
    joinedOk = (reqType == SYNC_TYPE) && (curJoined != '0);
    if (accept) begin
      case (barOp_e'(reqOp))
        OP_INIT:   if (handleLegal) stb.doInit = 1'b1; else stb.doErr = 1'b1;
        OP_SIGNAL: if (handleLegal) stb.doSignal = 1'b1; else stb.doErr = 1'b1;
        OP_JOIN:   if (handleLegal || handleNull) stb.doJoin = 1'b1; else stb.doErr = 1'b1;
        OP_WAIT: begin
          tgtId = curJoined;
          if (joinedOk) stb.doWait = 1'b1; else stb.doErr = 1'b1;
        end
        OP_LEAVE: begin
          tgtId = curJoined;
          if (joinedOk) stb.doLeave = 1'b1; else stb.doErr = 1'b1;
        end
        default:   stb.doErr = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/namedbar_dpath.sv
module namedbar_dpath
  import namedbar_pkg::*;
#(
  parameter int NUM_WAVES    = 8,
  parameter int NUM_BARRIERS = 16,
  localparam int WW   = $clog2(NUM_WAVES),
  localparam int CNTW = $clog2(NUM_WAVES + 1),
  localparam int IDW  = $clog2(NUM_BARRIERS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  barStrobe_t           stb,
  input  logic [IDW-1:0]       tgtId,
  input  logic [WW-1:0]        reqWave,
  input  logic [CNTW-1:0]      reqCount,
  output logic [IDW-1:0]       curJoined,
  output logic                 relValid,
  output logic [WW-1:0]        relWave,
  output logic [NUM_WAVES-1:0] waveStalled,
  output logic                 errPulse
);

  // barrier table, entry 0 is the unused null barrier
  logic [CNTW-1:0] memCnt [NUM_BARRIERS+1];
  logic [CNTW-1:0] arrCnt [NUM_BARRIERS+1];

  // per-wave state
  logic [IDW-1:0] joinedId [NUM_WAVES];
  logic           sigFlag  [NUM_WAVES];
  logic           doneFlag [NUM_WAVES];
  logic           waitFlag [NUM_WAVES];
  logic           relPend  [NUM_WAVES];

  logic [CNTW-1:0] curMem, newMem;
  logic [CNTW:0]   newArr;
  logic            complete, touchBar;

  always_comb begin
    curMem = memCnt[tgtId];
    newMem = curMem;
    newArr = {1'b0, arrCnt[tgtId]};
    if (stb.doInit) begin
      newMem = reqCount;
      newArr = '0;
    end
    if (stb.doSignal) begin
      if (reqCount != '0) newMem = reqCount;
      newArr = {1'b0, arrCnt[tgtId]} + 1'b1;
    end
    if (stb.doLeave && curMem != '0) newMem = curMem - 1'b1;
    complete = (stb.doSignal || stb.doLeave) && (newMem != '0) && (newArr >= {1'b0, newMem});
    touchBar = stb.doInit || stb.doSignal || stb.doLeave;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b <= NUM_BARRIERS; b++) begin
        memCnt[b] <= '0;
        arrCnt[b] <= '0;
      end
    end else if (touchBar) begin
      memCnt[tgtId] <= newMem;
      arrCnt[tgtId] <= complete ? '0 : newArr[CNTW-1:0];
    end
  end

  // lowest pending wave is released first
  always_comb begin
    relValid = 1'b0;
    relWave  = '0;
    for (int i = NUM_WAVES - 1; i >= 0; i--) begin
      if (relPend[i]) begin
        relValid = 1'b1;
        relWave  = WW'(i);
      end
    end
    for (int i = 0; i < NUM_WAVES; i++) waveStalled[i] = waitFlag[i] | relPend[i];
    curJoined = joinedId[reqWave];
  end

  for (genvar w = 0; w < NUM_WAVES; w++) begin : gWave
    logic isReq, hitBar, relNow;
    always_comb begin
      isReq  = (reqWave == WW'(w));
      hitBar = complete && (joinedId[w] == tgtId);
      relNow = relValid && (relWave == WW'(w));
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        joinedId[w] <= '0;
        sigFlag[w]  <= 1'b0;
        doneFlag[w] <= 1'b0;
        waitFlag[w] <= 1'b0;
        relPend[w]  <= 1'b0;
      end else begin
        if (relNow) relPend[w] <= 1'b0;
        if (hitBar) begin
          sigFlag[w] <= 1'b0;
          if (waitFlag[w]) begin
            waitFlag[w] <= 1'b0;
            relPend[w]  <= 1'b1;
          end else if (sigFlag[w] || (isReq && stb.doSignal)) begin
            doneFlag[w] <= 1'b1;
          end
        end else if (isReq && stb.doSignal && joinedId[w] == tgtId) begin
          sigFlag[w] <= 1'b1;
        end
        if (isReq && stb.doWait) begin
          if (doneFlag[w]) begin
            doneFlag[w] <= 1'b0;
            relPend[w]  <= 1'b1;
          end else begin
            waitFlag[w] <= 1'b1;
          end
        end
        if (isReq && (stb.doJoin || stb.doLeave)) begin
          joinedId[w] <= stb.doJoin ? tgtId : '0;
          sigFlag[w]  <= 1'b0;
          doneFlag[w] <= 1'b0;
          waitFlag[w] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) errPulse <= 1'b0;
    else       errPulse <= stb.doErr;
  end

endmodule

// File: rtl/namedbar_unit.sv
module namedbar_unit
  import namedbar_pkg::*;
#(
  parameter int NUM_WAVES    = 8,
  parameter int NUM_BARRIERS = 16,
  localparam int WW   = $clog2(NUM_WAVES),
  localparam int CNTW = $clog2(NUM_WAVES + 1),
  localparam int IDW  = $clog2(NUM_BARRIERS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [2:0]           reqOp,
  input  logic [WW-1:0]        reqWave,
  input  logic [31:0]          reqHandle,
  input  logic [CNTW-1:0]      reqCount,
  input  logic [1:0]           reqType,
  output logic                 relValid,
  output logic [WW-1:0]        relWave,
  output logic [NUM_WAVES-1:0] waveStalled,
  output logic                 errPulse
);

  barStrobe_t     stb;
  logic [IDW-1:0] handleId, tgtId, curJoined;
  logic           handleNull, handleLegal, accept;

  assign reqReady = !relValid;
  assign accept   = reqValid && reqReady;

  namedbar_hdec #(.NUM_BARRIERS(NUM_BARRIERS)) uHdec (
    .handle (reqHandle),
    .barId  (handleId),
    .isNull (handleNull),
    .isLegal(handleLegal)
  );

  namedbar_ctrl #(.NUM_BARRIERS(NUM_BARRIERS)) uCtrl (
    .accept     (accept),
    .reqOp      (reqOp),
    .reqType    (reqType),
    .handleId   (handleId),
    .handleNull (handleNull),
    .handleLegal(handleLegal),
    .curJoined  (curJoined),
    .stb        (stb),
    .tgtId      (tgtId)
  );

  namedbar_dpath #(.NUM_WAVES(NUM_WAVES), .NUM_BARRIERS(NUM_BARRIERS)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .tgtId      (tgtId),
    .reqWave    (reqWave),
    .reqCount   (reqCount),
    .curJoined  (curJoined),
    .relValid   (relValid),
    .relWave    (relWave),
    .waveStalled(waveStalled),
    .errPulse   (errPulse)
  );

endmodule

// File: rtl/namedbar_chk.sv
module namedbar_chk #(
  parameter int NUM_WAVES = 8,
  localparam int WW = $clog2(NUM_WAVES)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic                 relValid,
  input logic [WW-1:0]        relWave,
  input logic [NUM_WAVES-1:0] waveStalled,
  input logic                 errPulse
);

  AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    relValid |-> !reqReady); // R10

  AST_REL_FROM_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    relValid |-> waveStalled[relWave]); // R11

  AST_REL_ASCENDING: assert property (@(posedge clk) disable iff (!rstN)
    (relValid && $past(relValid)) |-> (relWave > $past(relWave))); // R4

  AST_REL_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(relValid) |-> $past(reqValid && reqReady)); // R4

  AST_ERR_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(reqValid && reqReady)); // R1

  AST_ERR_NO_STALL_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $stable(waveStalled)); // R9

endmodule

bind namedbar_unit namedbar_chk #(.NUM_WAVES(NUM_WAVES)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .relValid   (relValid),
  .relWave    (relWave),
  .waveStalled(waveStalled),
  .errPulse   (errPulse)
);

// File: tb/tb_namedbar_unit.sv
`timescale 1ns/1ps
module tb_namedbar_unit;
  import namedbar_pkg::*;

  localparam int NW = 4;
  localparam int NB = 16;
  localparam int WW = 2;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rstN;
  logic          reqValid;
  logic          reqReady;
  logic [2:0]    reqOp;
  logic [WW-1:0] reqWave;
  logic [31:0]   reqHandle;
  logic [CW-1:0] reqCount;
  logic [1:0]    reqType;
  logic          relValid;
  logic [WW-1:0] relWave;
  logic [NW-1:0] waveStalled;
  logic          errPulse;

  always #2 clk = ~clk;

  namedbar_unit #(.NUM_WAVES(NW), .NUM_BARRIERS(NB)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqWave(reqWave), .reqHandle(reqHandle), .reqCount(reqCount),
    .reqType(reqType), .relValid(relValid), .relWave(relWave),
    .waveStalled(waveStalled), .errPulse(errPulse)
  );

  int nChk  = 0;
  int nFail = 0;
  bit done  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hdl(input int id);
    return 32'h0080_0000 | (32'(id) << 4);
  endfunction

  // called at a negedge; returns at the negedge after acceptance
  task automatic issue(input logic [2:0] op, input int wave, input logic [31:0] h,
                       input int cnt, input int typ);
    reqValid  = 1'b1;
    reqOp     = op;
    reqWave   = WW'(wave);
    reqHandle = h;
    reqCount  = CW'(cnt);
    reqType   = 2'(typ);
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic opChk(input logic [2:0] op, input int wave, input logic [31:0] h,
                       input int cnt, input int typ, input bit expErr, input string tag);
    issue(op, wave, h, cnt, typ);
    chk(errPulse == expErr, tag, int'(errPulse), int'(expErr));
  endtask

  task automatic expectRel(input logic [NW-1:0] mask, input string tag);
    for (int w = 0; w < NW; w++) begin
      if (mask[w]) begin
        chk(relValid && relWave == WW'(w) && !reqReady && waveStalled[w], tag,
            relValid ? int'(relWave) : -1, w);
        @(negedge clk);
      end
    end
    chk(!relValid && reqReady && (waveStalled & mask) == '0, {tag, " end"},
        int'(relValid), 0);
  endtask

  // n members of barrier b, waves 0..n-1; first signal carries firstCnt
  task automatic runPhase(input int b, input int n, input int firstCnt);
    logic [NW-1:0] stallExp;
    stallExp = '0;
    for (int w = 0; w < n; w++) begin
      opChk(OP_SIGNAL, w, hdl(b), (w == 0) ? firstCnt : 0, 0, 1'b0, "R2 signal");
      if (w < n - 1) begin
        chk(!relValid, "R4 no early release", int'(relValid), 0);
        opChk(OP_WAIT, w, 32'h0, 0, 1, 1'b0, "R6 wait");
        stallExp[w] = 1'b1;
        chk(waveStalled == stallExp, "R11 stalled", int'(waveStalled), int'(stallExp));
      end
    end
    expectRel(NW'((1 << (n - 1)) - 1), firstCnt != 0 ? "R4 release" : "R5 reuse release");
    opChk(OP_WAIT, n - 1, 32'h0, 0, 1, 1'b0, "R6 late wait");
    expectRel(NW'(1 << (n - 1)), "R6 late release");
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqOp = '0; reqWave = '0;
    reqHandle = '0; reqCount = '0; reqType = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !relValid && !errPulse && waveStalled == '0, "reset state",
        int'(waveStalled), 0);

    // main sweep: every barrier, every member count, two phases
    for (int b = 1; b <= NB; b++) begin
      for (int n = 1; n <= NW; n++) begin
        for (int w = 0; w < n; w++) opChk(OP_JOIN, w, hdl(b), 0, 0, 1'b0, "R6 join");
        runPhase(b, n, n);
        runPhase(b, n, 0);
      end
    end

    // handle decode sweep on joins from wave 3
    for (int id = 0; id < 32; id++) begin
      opChk(OP_JOIN, 3, hdl(id), 0, 0, id > NB, "R1 join id field");
      opChk(OP_JOIN, 3, hdl(id) | 32'h1, 0, 0, 1'b1, "R1 low bit set");
      opChk(OP_JOIN, 3, hdl(id) | 32'h200, 0, 0, 1'b1, "R1 bit outside field");
      opChk(OP_JOIN, 3, hdl(id) ^ 32'h0100_0000, 0, 0, 1'b1, "R1 wrong base");
    end
    opChk(OP_SIGNAL, 0, hdl(0), 1, 0, 1'b1, "R1 signal null");
    opChk(OP_INIT, 0, hdl(0), 1, 0, 1'b1, "R1 init null");
    opChk(OP_INIT, 0, hdl(17), 1, 0, 1'b1, "R1 init out of range");

    // rejected join leaves wave 3 on barrier 5
    opChk(OP_JOIN, 3, hdl(5), 0, 0, 1'b0, "R6 join");
    opChk(OP_JOIN, 3, hdl(20), 0, 0, 1'b1, "R1 bad join");
    opChk(OP_SIGNAL, 3, hdl(5), 1, 0, 1'b0, "R2 signal");
    opChk(OP_WAIT, 3, 32'h0, 0, 1, 1'b0, "R1 join unchanged wait");
    expectRel(4'b1000, "R1 join unchanged release");

    // explicit init: count 2, no arrival recorded
    opChk(OP_INIT, 0, hdl(7), 2, 0, 1'b0, "R3 init");
    opChk(OP_JOIN, 0, hdl(7), 0, 0, 1'b0, "R6 join");
    opChk(OP_JOIN, 1, hdl(7), 0, 0, 1'b0, "R6 join");
    opChk(OP_SIGNAL, 0, hdl(7), 0, 0, 1'b0, "R3 signal");
    chk(!relValid, "R3 no arrival from init", int'(relValid), 0);
    opChk(OP_WAIT, 0, 32'h0, 0, 1, 1'b0, "R3 wait");
    opChk(OP_SIGNAL, 1, hdl(7), 0, 0, 1'b0, "R3 signal");
    expectRel(4'b0001, "R3 release");

    // leave that completes the barrier
    opChk(OP_INIT, 0, hdl(9), 3, 0, 1'b0, "R3 init");
    for (int w = 0; w < 3; w++) opChk(OP_JOIN, w, hdl(9), 0, 0, 1'b0, "R6 join");
    opChk(OP_SIGNAL, 0, hdl(9), 0, 0, 1'b0, "R7 signal");
    opChk(OP_WAIT, 0, 32'h0, 0, 1, 1'b0, "R7 wait");
    opChk(OP_SIGNAL, 1, hdl(9), 0, 0, 1'b0, "R7 signal");
    opChk(OP_WAIT, 1, 32'h0, 0, 1, 1'b0, "R7 wait");
    opChk(OP_LEAVE, 2, 32'h0, 0, 1, 1'b0, "R7 leave");
    expectRel(4'b0011, "R7 leave completes");
    opChk(OP_WAIT, 2, 32'h0, 0, 1, 1'b1, "R9 wait after leave");
    chk(waveStalled == '0, "R9 no stall", int'(waveStalled), 0);
    opChk(OP_SIGNAL, 0, hdl(9), 0, 0, 1'b0, "R7 signal");
    opChk(OP_WAIT, 0, 32'h0, 0, 1, 1'b0, "R7 wait");
    opChk(OP_SIGNAL, 1, hdl(9), 0, 0, 1'b0, "R7 signal");
    expectRel(4'b0001, "R7 count now two");
    opChk(OP_WAIT, 1, 32'h0, 0, 1, 1'b0, "R7 wait");
    expectRel(4'b0010, "R7 late release");

    // leave that does not complete
    opChk(OP_INIT, 0, hdl(10), 3, 0, 1'b0, "R3 init");
    for (int w = 0; w < 3; w++) opChk(OP_JOIN, w, hdl(10), 0, 0, 1'b0, "R6 join");
    opChk(OP_SIGNAL, 0, hdl(10), 0, 0, 1'b0, "R7 signal");
    opChk(OP_WAIT, 0, 32'h0, 0, 1, 1'b0, "R7 wait");
    opChk(OP_LEAVE, 2, 32'h0, 0, 1, 1'b0, "R7 leave");
    chk(!relValid && waveStalled == 4'b0001, "R7 leave no completion", int'(relValid), 0);
    opChk(OP_SIGNAL, 1, hdl(10), 0, 0, 1'b0, "R7 signal");
    expectRel(4'b0001, "R7 release after leave");
    opChk(OP_WAIT, 1, 32'h0, 0, 1, 1'b0, "R7 wait");
    expectRel(4'b0010, "R7 late release");

    // bad type operand
    opChk(OP_INIT, 0, hdl(11), 2, 0, 1'b0, "R3 init");
    opChk(OP_JOIN, 0, hdl(11), 0, 0, 1'b0, "R6 join");
    opChk(OP_JOIN, 1, hdl(11), 0, 0, 1'b0, "R6 join");
    opChk(OP_SIGNAL, 0, hdl(11), 0, 0, 1'b0, "R8 signal");
    opChk(OP_WAIT, 0, 32'h0, 0, 2, 1'b1, "R8 wait type 2");
    chk(waveStalled == '0, "R8 wait ignored", int'(waveStalled), 0);
    opChk(OP_WAIT, 0, 32'h0, 0, 1, 1'b0, "R8 wait");
    opChk(OP_LEAVE, 1, 32'h0, 0, 0, 1'b1, "R8 leave type 0");
    chk(!relValid, "R8 leave ignored", int'(relValid), 0);
    opChk(OP_SIGNAL, 1, hdl(11), 0, 0, 1'b0, "R8 signal");
    expectRel(4'b0001, "R8 release");

    // null joined wave
    opChk(OP_JOIN, 2, hdl(0), 0, 0, 1'b0, "R1 join null");
    opChk(OP_WAIT, 2, 32'h0, 0, 1, 1'b1, "R9 wait on null");
    opChk(OP_LEAVE, 2, 32'h0, 0, 1, 1'b1, "R9 leave on null");
    chk(waveStalled == '0 && reqReady, "R9 R10 idle", int'(waveStalled), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule